// File: doc/BRIEF.md
# Gated Counter/Timer Pair with Four Counting Structures

This block holds two independent counter/timers, each built from a low byte and a high byte, and configured through one shared 8-bit mode register. Each timer advances on a clock-enable tick or on falling edges of its own external count pin. An optional hardware gate lets an active-high level input pause or release the timer on top of its software run bit. Four counting structures can be chosen per timer: a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads itself from the high byte, and a split arrangement where timer 0 becomes two separate 8-bit counters and timer 1 freezes.

Software reaches the registers through a small synchronous bus with a one-cycle registered read port. The overflow flag of each timer is driven straight from a register. It stays set until software writes the control register.

Top module: `gtimer_pair`

## Requirements
- R1: After synchronous reset, every register (mode, control, all four count bytes) reads 0x00 and both flag outputs are 0.
- R2: Register addresses: control 0x88, mode 0x89, low byte of timer 0 0x8A, low byte of timer 1 0x8B, high byte of timer 0 0x8C, high byte of timer 1 0x8D. The mode register holds timer 1 in bits [7:4] and timer 0 in bits [3:0]. Each nibble is {gate enable, count-source select, mode[1:0]}. Control bit 0 is run bit 0, bit 1 is run bit 1, bit 2 is flag 0 and bit 3 is flag 1. A read returns data on rd_data one cycle after rd_addr is presented.
- R3: Mode 00 counts the 13-bit value {high byte, low byte[4:0]}. Bits [7:5] of the low byte keep their value. When the value rolls from 0x1FFF to 0, the timer's flag is set.
- R4: Mode 01 counts the 16-bit value {high, low}. When the value rolls from 0xFFFF to 0, the timer's flag is set.
- R5: In mode 10 only the low byte counts. When the low byte overflows from 0xFF, it takes the value of the high byte and the flag is set. The high byte does not change.
- R6: A timer runs only while its run bit is 1 and either its gate enable is 0 or its gate input is 1. While a timer is not running, its count holds.
- R7: When the count-source select is 1, the timer advances by exactly one for each falling edge on its count pin, seen through a two-flop synchronizer, and ignores its tick input. When the select is 0, it advances once per cycle in which its tick is high.
- R8: When timer 0 is in mode 11, its low byte is an 8-bit counter under timer 0's gate, source and run bit, and it sets flag 0. Its high byte is a second 8-bit counter that advances on tick0 only while run bit 1 is 1, and sets flag 1. In this mode an overflow of timer 1 does not set flag 1.
- R9: When timer 1 is in mode 11, its count holds whatever its inputs do.
- R10: A bus write to a count byte takes priority over an increment in the same cycle. In modes 00, 01 and 10, a write to either byte of a timer drops that timer's increment for that cycle. In split mode, a write drops only the increment of the byte written.
- R11: A flag stays set until a control register write loads it from the written bit. A control write takes priority over a hardware set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data |
| tick0 | input | 1 | Count enable for timer 0 (also drives the split high byte) |
| tick1 | input | 1 | Count enable for timer 1 |
| cnt0_pin | input | 1 | External count pin, timer 0 |
| cnt1_pin | input | 1 | External count pin, timer 1 |
| gate0 | input | 1 | Active-high gate level, timer 0 |
| gate1 | input | 1 | Active-high gate level, timer 1 |
| tf0 | output | 1 | Overflow flag, timer 0 |
| tf1 | output | 1 | Overflow flag, timer 1 |

## Verification
The bench builds the block with its default parameters: 8-bit count bytes, a 5-bit prescale field in mode 00 and a two-stage synchronizer. With 8-bit bytes, a burst of a few hundred ticks crosses a byte boundary, wraps the 16-bit value from near 0xFFFF, and wraps the auto-reload byte several times. That lets the bench sweep modes 00 to 10 on both timers, over several start values and burst lengths, and compare against counts computed arithmetically. Dedicated sequences cover gating, pin edge counting, split mode, the frozen timer 1, write priority and flag clearing.

// File: rtl/gtp_pkg.sv
package gtp_pkg;
  parameter int BYTE_W = 8;
  parameter int PRE_W  = 5;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmode_t;

  typedef struct packed {
    logic   gate_en;
    logic   src_pin;
    tmode_t mode;
  } tcfg_t;
endpackage

// File: rtl/gtp_edge_sync.sv
module gtp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/gtp_timer_unit.sv
module gtp_timer_unit
  import gtp_pkg::*;
#(
  parameter int BW       = BYTE_W,
  parameter int PW       = PRE_W,
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  tmode_t        mode,
  input  logic          inc_lo,
  input  logic          inc_hi,
  input  logic          wr_tl,
  input  logic          wr_th,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] tl,
  output logic [BW-1:0] th,
  output logic          ovf_lo,
  output logic          ovf_hi
);
  logic [BW-1:0] tl_n, th_n;
  logic [PW-1:0] low;
  logic          blk_main;

  always_comb begin
    tl_n     = tl;
    th_n     = th;
    ovf_lo   = 1'b0;
    ovf_hi   = 1'b0;
    low      = tl[PW-1:0];
    blk_main = wr_tl | wr_th;
    case (mode)
      MODE_13: if (inc_lo && !blk_main) begin
        if (&low) begin
          tl_n[PW-1:0] = '0;
          th_n         = th + 1'b1;
          ovf_lo       = &th;
        end else begin
          tl_n[PW-1:0] = low + 1'b1;
        end
      end
      MODE_16: if (inc_lo && !blk_main) begin
        {th_n, tl_n} = {th, tl} + 1'b1;
        ovf_lo       = &{th, tl};
      end
      MODE_RELOAD: if (inc_lo && !blk_main) begin
        if (&tl) begin
          tl_n   = th;
          ovf_lo = 1'b1;
        end else begin
          tl_n = tl + 1'b1;
        end
      end
      default: if (SPLIT_OK) begin
        if (inc_lo && !wr_tl) begin
          tl_n   = tl + 1'b1;
          ovf_lo = &tl;
        end
        if (inc_hi && !wr_th) begin
          th_n   = th + 1'b1;
          ovf_hi = &th;
        end
      end
    endcase
    if (wr_tl) tl_n = wr_data;
    if (wr_th) th_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tl <= '0;
      th <= '0;
    end else begin
      tl <= tl_n;
      th <= th_n;
    end
  end

  // R10
  tl_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_tl |=> tl == $past(wr_data));

  // R10
  th_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_th |=> th == $past(wr_data));
endmodule

// File: rtl/gtimer_pair.sv
module gtimer_pair
  import gtp_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [7:0]  A_CTRL      = 8'h88,
  parameter logic [7:0]  A_MODE      = 8'h89,
  parameter logic [7:0]  A_TL0       = 8'h8A,
  parameter logic [7:0]  A_TL1       = 8'h8B,
  parameter logic [7:0]  A_TH0       = 8'h8C,
  parameter logic [7:0]  A_TH1       = 8'h8D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic              tick0,
  input  logic              tick1,
  input  logic              cnt0_pin,
  input  logic              cnt1_pin,
  input  logic              gate0,
  input  logic              gate1,
  output logic              tf0,
  output logic              tf1
);
  localparam int NT = 2;

  logic [7:0]    mode_q;
  logic          tr0_q, tr1_q, tf0_q, tf1_q;
  logic [7:0]    rd_q;
  tcfg_t         cfg0, cfg1;
  logic [NT-1:0] pin_v, fall_v;
  logic          split0, run0, run1, inc0, inc1, inc0_hi;
  logic          wr_ctrl, wr_tl0, wr_th0, wr_tl1, wr_th1;
  logic [7:0]    tl0, th0, tl1, th1;
  logic          ovf0_lo, ovf0_hi, ovf1_lo, ovf1_hi;
  logic          set0, set1;

  assign cfg0  = tcfg_t'(mode_q[3:0]);
  assign cfg1  = tcfg_t'(mode_q[7:4]);
  assign pin_v = {cnt1_pin, cnt0_pin};

  for (genvar g = 0; g < NT; g++) begin : g_sync
    gtp_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk (clk),
      .rst (rst),
      .pin (pin_v[g]),
      .fall(fall_v[g])
    );
  end

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_tl0  = wr_en && (wr_addr == ADDR_W'(A_TL0));
  assign wr_th0  = wr_en && (wr_addr == ADDR_W'(A_TH0));
  assign wr_tl1  = wr_en && (wr_addr == ADDR_W'(A_TL1));
  assign wr_th1  = wr_en && (wr_addr == ADDR_W'(A_TH1));

  assign split0  = (cfg0.mode == MODE_SPLIT);
  assign run0    = tr0_q & (~cfg0.gate_en | gate0);
  assign run1    = tr1_q & (~cfg1.gate_en | gate1);
  assign inc0    = run0 & (cfg0.src_pin ? fall_v[0] : tick0);
  assign inc1    = run1 & (cfg1.src_pin ? fall_v[1] : tick1);
  assign inc0_hi = split0 & tr1_q & tick0;

  gtp_timer_unit #(.BW(BYTE_W), .PW(PRE_W), .SPLIT_OK(1'b1)) i_t0 (
    .clk(clk), .rst(rst), .mode(cfg0.mode),
    .inc_lo(inc0), .inc_hi(inc0_hi),
    .wr_tl(wr_tl0), .wr_th(wr_th0), .wr_data(wr_data),
    .tl(tl0), .th(th0), .ovf_lo(ovf0_lo), .ovf_hi(ovf0_hi)
  );

  gtp_timer_unit #(.BW(BYTE_W), .PW(PRE_W), .SPLIT_OK(1'b0)) i_t1 (
    .clk(clk), .rst(rst), .mode(cfg1.mode),
    .inc_lo(inc1), .inc_hi(1'b0),
    .wr_tl(wr_tl1), .wr_th(wr_th1), .wr_data(wr_data),
    .tl(tl1), .th(th1), .ovf_lo(ovf1_lo), .ovf_hi(ovf1_hi)
  );

  assign set0 = ovf0_lo;
  assign set1 = split0 ? ovf0_hi : (ovf1_lo | ovf1_hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      tr0_q  <= 1'b0;
      tr1_q  <= 1'b0;
      tf0_q  <= 1'b0;
      tf1_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_MODE)) mode_q <= wr_data;
      if (wr_ctrl) begin
        tr0_q <= wr_data[0];
        tr1_q <= wr_data[1];
        tf0_q <= wr_data[2];
        tf1_q <= wr_data[3];
      end else begin
        tf0_q <= tf0_q | set0;
        tf1_q <= tf1_q | set1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(A_CTRL): rd_q <= {4'b0, tf1_q, tf0_q, tr1_q, tr0_q};
        ADDR_W'(A_MODE): rd_q <= mode_q;
        ADDR_W'(A_TL0):  rd_q <= tl0;
        ADDR_W'(A_TL1):  rd_q <= tl1;
        ADDR_W'(A_TH0):  rd_q <= th0;
        ADDR_W'(A_TH1):  rd_q <= th1;
        default:         rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign tf0     = tf0_q;
  assign tf1     = tf1_q;

  // R6
  gate0_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg0.gate_en && !gate0 && !wr_tl0 && !wr_th0) |=> $stable(tl0));

  // R9
  t1_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg1.mode == MODE_SPLIT && !wr_tl1 && !wr_th1) |=> $stable({th1, tl1}));

  // R8
  th0_split_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (split0 && !tr1_q && !wr_th0) |=> $stable(th0));

  // R11
  tf0_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (tf0_q && !wr_ctrl) |=> tf0_q);
endmodule

// File: tb/test_gtimer_pair.sv
module test_gtimer_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       tick0 = 1'b0, tick1 = 1'b0;
  logic       cnt0_pin = 1'b1, cnt1_pin = 1'b1;
  logic       gate0 = 1'b0, gate1 = 1'b0;
  logic       tf0, tf1;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gtimer_pair i_gtimer_pair (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick0(tick0), .tick1(tick1),
    .cnt0_pin(cnt0_pin), .cnt1_pin(cnt1_pin), .gate0(gate0), .gate1(gate1),
    .tf0(tf0), .tf1(tf1)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = int'(rd_data);
  endtask

  task automatic ticks(input int t, input int n);
    @(negedge clk);
    if (t == 0) tick0 = 1'b1; else tick1 = 1'b1;
    repeat (n) @(negedge clk);
    tick0 = 1'b0; tick1 = 1'b0;
  endtask

  task automatic model(input int m, input int th, input int tl, input int n,
                       output int eth, output int etl, output int eovf);
    int v, r;
    eth = th; etl = tl; eovf = 0;
    if (m == 0) begin
      v = th * 32 + (tl % 32) + n;
      eovf = (v >= 8192) ? 1 : 0;
      v = v % 8192;
      etl = (tl / 32) * 32 + (v % 32);
      eth = v / 32;
    end else if (m == 1) begin
      v = th * 256 + tl + n;
      eovf = (v >= 65536) ? 1 : 0;
      v = v % 65536;
      etl = v % 256;
      eth = v / 256;
    end else begin
      if (tl + n < 256) etl = tl + n;
      else begin
        r = n - (256 - tl);
        etl = th + (r % (256 - th));
        eovf = 1;
      end
    end
  endtask

  initial begin
    int d, eth, etl, eovf;
    int sth[4] = '{8'h00, 8'hFF, 8'h12, 8'hFF};
    int stl[4] = '{8'h00, 8'hFE, 8'hF0, 8'hE1};
    int nn[3] = '{3, 37, 300};
    logic [7:0] atl, ath;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h89, d); chk("R1 mode reset", d, 0);
    rd(8'h88, d); chk("R1 ctrl reset", d, 0);
    rd(8'h8A, d); chk("R1 tl0 reset", d, 0);
    rd(8'h8D, d); chk("R1 th1 reset", d, 0);
    chk("R1 tf0 reset", int'(tf0), 0);
    chk("R1 tf1 reset", int'(tf1), 0);

    // R2 readback
    wr(8'h89, 8'hA5); rd(8'h89, d); chk("R2 mode readback", d, 8'hA5);
    wr(8'h88, 8'h0A); rd(8'h88, d); chk("R2 ctrl readback", d, 8'h0A);
    wr(8'h88, 8'h00); wr(8'h89, 8'h00);

    // R3 R4 R5 sweep over modes, start values, burst lengths, both timers
    for (int t = 0; t < 2; t++) begin
      atl = (t == 0) ? 8'h8A : 8'h8B;
      ath = (t == 0) ? 8'h8C : 8'h8D;
      for (int m = 0; m < 3; m++) begin
        for (int s = 0; s < 4; s++) begin
          for (int k = 0; k < 3; k++) begin
            wr(8'h88, 8'h00);
            wr(8'h89, (t == 0) ? 8'(m) : 8'(m << 4));
            wr(atl, 8'(stl[s]));
            wr(ath, 8'(sth[s]));
            wr(8'h88, (t == 0) ? 8'h01 : 8'h02);
            ticks(t, nn[k]);
            model(m, sth[s], stl[s], nn[k], eth, etl, eovf);
            chk((m == 0) ? "R3 flag" : (m == 1) ? "R4 flag" : "R5 flag",
                (t == 0) ? int'(tf0) : int'(tf1), eovf);
            rd(atl, d);
            chk((m == 0) ? "R3 low" : (m == 1) ? "R4 low" : "R5 low", d, etl);
            rd(ath, d);
            chk((m == 0) ? "R3 high" : (m == 1) ? "R4 high" : "R5 high", d, eth);
          end
        end
      end
    end

    // R11 flag sticky then cleared by control write
    wr(8'h88, 8'h00); wr(8'h89, 8'h01);
    wr(8'h8A, 8'hFF); wr(8'h8C, 8'hFF); wr(8'h88, 8'h01);
    ticks(0, 1);
    repeat (10) @(negedge clk);
    chk("R11 tf0 sticky", int'(tf0), 1);
    wr(8'h88, 8'h00);
    chk("R11 tf0 cleared", int'(tf0), 0);

    // R6 gating
    wr(8'h89, 8'h09); wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    gate0 = 1'b0;
    ticks(0, 10); rd(8'h8A, d); chk("R6 tr0 off holds", d, 0);
    wr(8'h88, 8'h01);
    ticks(0, 10); rd(8'h8A, d); chk("R6 gate low holds", d, 0);
    gate0 = 1'b1;
    ticks(0, 10); rd(8'h8A, d); chk("R6 gate high runs", d, 10);
    gate0 = 1'b0;
    wr(8'h89, 8'h01);
    ticks(0, 5); rd(8'h8A, d); chk("R6 gate off runs", d, 15);

    // R7 external pin edges, tick ignored
    wr(8'h88, 8'h00); wr(8'h89, 8'h05); wr(8'h8A, 8'h00); wr(8'h8C, 8'h00);
    wr(8'h88, 8'h01);
    @(negedge clk); tick0 = 1'b1;
    for (int e = 0; e < 7; e++) begin
      cnt0_pin = 1'b0; repeat (3) @(negedge clk);
      cnt0_pin = 1'b1; repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk); tick0 = 1'b0;
    rd(8'h8A, d); chk("R7 pin edges counted", d, 7);

    // R10 write beats increment
    wr(8'h89, 8'h01); wr(8'h8A, 8'h00);
    @(negedge clk);
    tick0 = 1'b1; wr_en = 1'b1; wr_addr = 8'h8A; wr_data = 8'h55;
    @(negedge clk);
    tick0 = 1'b0; wr_en = 1'b0;
    rd(8'h8A, d); chk("R10 write priority", d, 8'h55);

    // R8 split mode
    wr(8'h88, 8'h00); wr(8'h89, 8'h13);
    wr(8'h8A, 8'hFE); wr(8'h8C, 8'hFD); wr(8'h8B, 8'h00); wr(8'h8D, 8'h00);
    wr(8'h88, 8'h03);
    ticks(0, 3);
    chk("R8 tf0 low byte", int'(tf0), 1);
    chk("R8 tf1 high byte", int'(tf1), 1);
    rd(8'h8A, d); chk("R8 tl0", d, 8'h01);
    rd(8'h8C, d); chk("R8 th0", d, 8'h00);
    rd(8'h8B, d); chk("R8 tl1 untouched", d, 8'h00);
    wr(8'h88, 8'h02);
    ticks(0, 4);
    rd(8'h8A, d); chk("R8 tl0 stopped", d, 8'h01);
    rd(8'h8C, d); chk("R8 th0 under tr1", d, 8'h04);
    wr(8'h88, 8'h01);
    ticks(0, 2);
    rd(8'h8A, d); chk("R8 tl0 under tr0", d, 8'h03);
    rd(8'h8C, d); chk("R8 th0 held", d, 8'h04);
    wr(8'h88, 8'h02); wr(8'h8B, 8'hFF); wr(8'h8D, 8'hFF);
    ticks(1, 1);
    rd(8'h8B, d); chk("R8 t1 still wraps", d, 8'h00);
    chk("R8 t1 overflow no tf1", int'(tf1), 0);

    // R9 timer 1 frozen in mode 11
    wr(8'h88, 8'h00); wr(8'h89, 8'h30); wr(8'h8B, 8'h40); wr(8'h8D, 8'h22);
    wr(8'h88, 8'h02);
    ticks(1, 5);
    rd(8'h8B, d); chk("R9 tl1 held", d, 8'h40);
    rd(8'h8D, d); chk("R9 th1 held", d, 8'h22);
    chk("R9 no flag", int'(tf1), 0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule